// File: doc/BRIEF.md
# DMA Controller CPU Register Port

This block is the processor-side programming port of a four-channel DMA controller, active while the controller is idle. A processor selects it with an active-low chip select and performs byte reads and writes through active-low read and write strobes and a 4-bit register address. Read data leaves on an 8-bit output with its own output enable, so a pad ring can form the bidirectional bus. The enable is raised only while a processor read is in progress.

The port holds the command, request and mask registers, four channel mode registers with a mode-readback counter, and the 16-bit base/current address and count registers of each channel. Each 16-bit register is reached as two bytes, low then high, steered by a shared byte pointer. Every strobe is accepted in the cycle it is seen: the bus has no back-pressure, no wait states and no valid/ready pair. A write takes effect at the first clock edge that sees the write strobe low. A read returns data combinationally while the strobe is held, and its side effects happen at the first edge after the strobe is released.

Top module: `dmareg_port`

## Requirements
- R1: While `rst` is high, and in the cycle after, all four mask bits are 1 and the command, request, mode counter and byte pointer are 0. After reset, address 15 reads 0x0F and addresses 8, 9 and 11 read 0x00.
- R2: With `cs_n` high, the read and write strobes have no effect. No register changes and `dout_oe` stays 0.
- R3: `dout_oe` is 1 only while `cs_n`, `rd_n` are low and `wr_n` is high. A write never raises it, and `dout` is 0 whenever `dout_oe` is 0.
- R4: Addresses 0 to 7 select channel `addr[2:1]`. `addr[0]`=0 selects the address register and `addr[0]`=1 the count register. The low byte is moved when the byte pointer is 0 and the high byte when it is 1. The pointer flips after every such read or write.
- R5: A write of any data to address 12 sets the byte pointer to 0.
- R6: A write to a channel register loads the base and the current copy together. A read returns the current copy, and the data stays steady for as long as the read is held.
- R7: A write to address 11 stores `din[7:2]` as the mode of channel `din[1:0]` and advances a 2-bit mode counter, which wraps from 3 to 0. A read of address 11 returns {mode of channel `counter`, `counter`}.
- R8: A write to address 8 loads the 8-bit command register. A read of address 9 returns it.
- R9: A write to address 9 sets request bit `din[1:0]` to `din[2]`. A read of address 8 returns the status {request[3:0], 4'b0000}.
- R10: A write to address 10 sets mask bit `din[1:0]` to `din[2]`. A write to address 14 clears all mask bits. A write to address 15 loads the mask from `din[3:0]`. A read of address 15 returns {4'b0000, mask}.
- R11: A write of any data to address 13 has the same effect on the control registers as reset, and leaves the channel registers unchanged. A read of address 13 returns the temporary register, which is 0x00 here.
- R12: Reads of addresses 10, 12 and 14 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| addr | input | 4 | Register address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_oe | output | 1 | Drive enable for the read data |

## Verification
A byte pointer in the wrong state shows up at the next channel read as the other half of the 16-bit value. Because the pointer is shared, every later channel access stays swapped until address 12 is written or a master clear occurs. A wrong mode counter shows on the very next read of address 11, whose low two bits expose it. A lost or spurious mask, request or command update shows on the next read of its readback address. The bench mixes random accesses with these readbacks, so such a fault appears within a few accesses of its cause.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD_STAT = 4'd8,
    SEL_REQ_CMD  = 4'd9,
    SEL_MASK_ONE = 4'd10,
    SEL_MODE     = 4'd11,
    SEL_PTR_CLR  = 4'd12,
    SEL_MCLR_TMP = 4'd13,
    SEL_MASK_CLR = 4'd14,
    SEL_MASK_ALL = 4'd15
  } reg_sel_e;

  typedef struct packed {
    logic              wr;
    logic              rd_end;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] data;
  } acc_t;
endpackage

// File: rtl/dmareg_strobe.sv
module dmareg_strobe
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [SEL_W-1:0]  addr,
  input  logic [BYTE_W-1:0] din,
  output acc_t              acc,
  output logic              rd_act
);
  logic wr_act, rd_q, wr_q;
  logic [SEL_W-1:0] rsel_q;

  assign rd_act = !cs_n && !rd_n && wr_n;
  assign wr_act = !cs_n && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      rsel_q <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (rd_act) rsel_q <= addr;
    end
  end

  always_comb begin
    acc.wr     = wr_act && !wr_q;
    acc.rd_end = rd_q && !rd_act;
    acc.sel    = acc.wr ? addr : rsel_q;
    acc.data   = din;
  end
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
  import dmareg_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  output logic              bptr,
  output logic [BYTE_W-1:0] cmd,
  output logic [NCH-1:0]    req,
  output logic [NCH-1:0]    mask,
  output logic [$clog2(NCH)-1:0] mode_cnt,
  output logic [BYTE_W-3:0] mode_sel
);
  localparam int unsigned CHW  = $clog2(NCH);
  localparam int unsigned MDW  = BYTE_W - 2;

  logic [MDW-1:0] mode_q [NCH];
  logic           chan_acc, mclr;
  logic [CHW-1:0] tgt;

  assign chan_acc = (acc.wr || acc.rd_end) && !acc.sel[SEL_W-1];
  assign mclr     = acc.wr && (acc.sel == SEL_MCLR_TMP);
  assign tgt      = acc.data[CHW-1:0];
  assign mode_sel = mode_q[mode_cnt];

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      cmd      <= '0;
      req      <= '0;
      mask     <= '1;
      mode_cnt <= '0;
      bptr     <= 1'b0;
    end else begin
      if (chan_acc) bptr <= !bptr;
      if (acc.wr) begin
        case (reg_sel_e'(acc.sel))
          SEL_CMD_STAT: cmd            <= acc.data;
          SEL_REQ_CMD:  req[tgt]       <= acc.data[2];
          SEL_MASK_ONE: mask[tgt]      <= acc.data[2];
          SEL_MODE:     mode_cnt       <= mode_cnt + 1'b1;
          SEL_PTR_CLR:  bptr           <= 1'b0;
          SEL_MASK_CLR: mask           <= '0;
          SEL_MASK_ALL: mask           <= acc.data[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst) mode_q[c] <= '0;
        else if (acc.wr && acc.sel == SEL_MODE && tgt == CHW'(c))
          mode_q[c] <= acc.data[BYTE_W-1:2];
      end
    end
  endgenerate
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  input  logic              bptr,
  input  logic [SEL_W-1:0]  rsel,
  output logic [BYTE_W-1:0] rbyte,
  output logic [NCH*CW-1:0] base_a_flat,
  output logic [NCH*CW-1:0] cur_a_flat,
  output logic [NCH*CW-1:0] base_c_flat,
  output logic [NCH*CW-1:0] cur_c_flat
);
  localparam int unsigned CHW = $clog2(NCH);

  logic [CW-1:0] cur_a [NCH];
  logic [CW-1:0] cur_c [NCH];
  logic [CW-1:0] sel_word;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0] base_a, base_c;
      logic hit_a, hit_c;
      assign hit_a = acc.wr && !acc.sel[SEL_W-1] && acc.sel[CHW:1] == CHW'(c) && !acc.sel[0];
      assign hit_c = acc.wr && !acc.sel[SEL_W-1] && acc.sel[CHW:1] == CHW'(c) &&  acc.sel[0];

      always_ff @(posedge clk) begin
        if (rst) begin
          base_a <= '0;
          base_c <= '0;
        end else begin
          if (hit_a) begin
            if (bptr) base_a[CW-1:BYTE_W] <= acc.data;
            else      base_a[BYTE_W-1:0]  <= acc.data;
          end
          if (hit_c) begin
            if (bptr) base_c[CW-1:BYTE_W] <= acc.data;
            else      base_c[BYTE_W-1:0]  <= acc.data;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cur_a[c] <= '0;
          cur_c[c] <= '0;
        end else begin
          if (hit_a) begin
            if (bptr) cur_a[c][CW-1:BYTE_W] <= acc.data;
            else      cur_a[c][BYTE_W-1:0]  <= acc.data;
          end
          if (hit_c) begin
            if (bptr) cur_c[c][CW-1:BYTE_W] <= acc.data;
            else      cur_c[c][BYTE_W-1:0]  <= acc.data;
          end
        end
      end

      assign base_a_flat[c*CW +: CW] = base_a;
      assign base_c_flat[c*CW +: CW] = base_c;
      assign cur_a_flat[c*CW +: CW]  = cur_a[c];
      assign cur_c_flat[c*CW +: CW]  = cur_c[c];
    end
  endgenerate

  assign sel_word = rsel[0] ? cur_c[rsel[CHW:1]] : cur_a[rsel[CHW:1]];
  assign rbyte    = bptr ? sel_word[CW-1:BYTE_W] : sel_word[BYTE_W-1:0];
endmodule

// File: rtl/dmareg_port.sv
module dmareg_port
  import dmareg_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [SEL_W-1:0]  addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);
  localparam int unsigned CHW = $clog2(NCH);

  acc_t acc;
  logic rd_act, bptr_q;
  logic wr_ev, rd_end_ev;
  logic [SEL_W-1:0] ev_sel;
  logic [BYTE_W-1:0] cmd_q, chan_byte, rmux;
  logic [NCH-1:0] req_q, mask_q;
  logic [CHW-1:0] mode_cnt_q;
  logic [BYTE_W-3:0] mode_sel;
  logic [NCH*CW-1:0] base_a_flat, cur_a_flat, base_c_flat, cur_c_flat;

  dmareg_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .acc(acc), .rd_act(rd_act)
  );

  dmareg_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .acc(acc), .bptr(bptr_q), .cmd(cmd_q),
    .req(req_q), .mask(mask_q), .mode_cnt(mode_cnt_q), .mode_sel(mode_sel)
  );

  dmareg_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .acc(acc), .bptr(bptr_q), .rsel(addr),
    .rbyte(chan_byte), .base_a_flat(base_a_flat), .cur_a_flat(cur_a_flat),
    .base_c_flat(base_c_flat), .cur_c_flat(cur_c_flat)
  );

  assign wr_ev     = acc.wr;
  assign rd_end_ev = acc.rd_end;
  assign ev_sel    = acc.sel;

  always_comb begin
    rmux = '0;
    if (!addr[SEL_W-1]) rmux = chan_byte;
    else begin
      case (reg_sel_e'(addr))
        SEL_CMD_STAT: rmux = {req_q, {(BYTE_W-NCH){1'b0}}};
        SEL_REQ_CMD:  rmux = cmd_q;
        SEL_MODE:     rmux = {mode_sel, mode_cnt_q};
        SEL_MASK_ALL: rmux = {{(BYTE_W-NCH){1'b0}}, mask_q};
        default:      rmux = '0;
      endcase
    end
  end

  assign dout_oe = rd_act;
  assign dout    = rd_act ? rmux : '0;
endmodule

// File: rtl/dmareg_port_chk.sv
module dmareg_port_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic [3:0]        addr,
  input logic [7:0]        dout,
  input logic              dout_oe,
  input logic              wr_ev,
  input logic              rd_end_ev,
  input logic [3:0]        ev_sel,
  input logic              bptr,
  input logic [NCH-1:0]    mask,
  input logic [$clog2(NCH)-1:0] mode_cnt,
  input logic [NCH*CW-1:0] base_a_flat,
  input logic [NCH*CW-1:0] cur_a_flat,
  input logic [NCH*CW-1:0] base_c_flat,
  input logic [NCH*CW-1:0] cur_c_flat
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask == '1 && !bptr && mode_cnt == '0));

  assert_deselect_inert_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!dout_oe && !wr_ev));

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !dout_oe);

  assert_ptr_flips_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_ev || rd_end_ev) && !ev_sel[3]) |=> (bptr != $past(bptr)));

  assert_base_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    (base_a_flat == cur_a_flat) && (base_c_flat == cur_c_flat));

  assert_read_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(dout_oe) && $stable(addr)) |-> $stable(dout));

  assert_modecnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_ev |=> $stable(mode_cnt));

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_ev |=> $stable(mask));
endmodule

bind dmareg_port dmareg_port_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
  .dout(dout), .dout_oe(dout_oe), .wr_ev(wr_ev), .rd_end_ev(rd_end_ev),
  .ev_sel(ev_sel), .bptr(bptr_q), .mask(mask_q), .mode_cnt(mode_cnt_q),
  .base_a_flat(base_a_flat), .cur_a_flat(cur_a_flat),
  .base_c_flat(base_c_flat), .cur_c_flat(cur_c_flat)
);

// File: tb/dmareg_port_bench.sv
module dmareg_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_a [4];
  logic [15:0] m_c [4];
  logic [7:0]  m_cmd;
  logic [3:0]  m_req, m_mask;
  logic [5:0]  m_mode [4];
  logic [1:0]  m_cnt;
  logic        m_bp;

  always #5 clk = ~clk;

  dmareg_port u_dmareg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic void model_ctrl_clear();
    m_cmd = '0; m_req = '0; m_mask = 4'hF; m_cnt = '0; m_bp = 1'b0;
  endfunction

  function automatic logic [7:0] model_read(input logic [3:0] a);
    logic [15:0] w;
    if (!a[3]) begin
      w = a[0] ? m_c[a[2:1]] : m_a[a[2:1]];
      return m_bp ? w[15:8] : w[7:0];
    end
    case (a)
      4'd8:  return {m_req, 4'h0};
      4'd9:  return m_cmd;
      4'd11: return {m_mode[m_cnt], m_cnt};
      4'd15: return {4'h0, m_mask};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    if (!a[3]) return "R4/R6";
    case (a)
      4'd8:  return "R9";
      4'd9:  return "R8";
      4'd11: return "R7";
      4'd13: return "R11";
      4'd15: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
    if (!a[3]) begin
      if (a[0]) begin
        if (m_bp) m_c[a[2:1]][15:8] = d; else m_c[a[2:1]][7:0] = d;
      end else begin
        if (m_bp) m_a[a[2:1]][15:8] = d; else m_a[a[2:1]][7:0] = d;
      end
      m_bp = !m_bp;
    end else begin
      case (a)
        4'd8:  m_cmd = d;
        4'd9:  m_req[d[1:0]] = d[2];
        4'd10: m_mask[d[1:0]] = d[2];
        4'd11: begin m_mode[d[1:0]] = d[7:2]; m_cnt = m_cnt + 2'd1; end
        4'd12: m_bp = 1'b0;
        4'd13: model_ctrl_clear();
        4'd14: m_mask = 4'h0;
        default: m_mask = d[3:0];
      endcase
    end
  endfunction

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    #1 check(dout_oe == 1'b0, "R3", dout_oe, 0);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    model_write(a, d);
    @(negedge clk);
  endtask

  task automatic cpu_rd(input logic [3:0] a);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    #1;
    e = model_read(a);
    check(dout_oe == 1'b1, "R3", dout_oe, 1);
    check(dout == e, req_of(a), dout, e);
    cs_n = 1'b1; rd_n = 1'b1;
    if (!a[3]) m_bp = !m_bp;
    @(negedge clk);
    #1 check(dout_oe == 1'b0 && dout == 8'h00, "R3", {dout_oe, dout}, 0);
  endtask

  task automatic ghost(input logic [3:0] a, input logic [7:0] d, input bit is_rd);
    @(negedge clk);
    cs_n = 1'b1; addr = a; din = d;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    #1 check(dout_oe == 1'b0, "R2", dout_oe, 0);
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_c[i] = '0; m_mode[i] = '0; end
    model_ctrl_clear();
    repeat (3) @(negedge clk);
    #1 check(dout_oe == 1'b0, "R1", dout_oe, 0);
    rst = 1'b0;
    cpu_rd(4'd15);
    cpu_rd(4'd8);
    cpu_rd(4'd9);
    cpu_rd(4'd11);
    // R4 R6: two-byte address load on channel 2, then byte-ordered readback
    cpu_wr(4'd4, 8'h34);
    cpu_wr(4'd4, 8'h12);
    cpu_rd(4'd4);
    cpu_rd(4'd4);
    // R5: pointer cleared mid-pair so the next byte lands low again
    cpu_wr(4'd7, 8'hAA);
    cpu_wr(4'd12, 8'h5C);
    cpu_wr(4'd7, 8'hBB);
    cpu_wr(4'd7, 8'hCC);
    cpu_rd(4'd7);
    cpu_rd(4'd7);
    // R7: five mode writes, counter wraps to 1
    for (int k = 0; k < 5; k++) cpu_wr(4'd11, {6'(k * 9 + 3), 2'(k)});
    cpu_rd(4'd11);
    // R8 R9 R10
    cpu_wr(4'd8, 8'hA5);
    cpu_rd(4'd9);
    cpu_wr(4'd9, 8'h06);
    cpu_rd(4'd8);
    cpu_wr(4'd14, 8'hFF);
    cpu_wr(4'd10, 8'h07);
    cpu_rd(4'd15);
    // R2: deselected write to the mask must be ignored
    ghost(4'd15, 8'h00, 1'b0);
    ghost(4'd0, 8'h77, 1'b1);
    cpu_rd(4'd15);
    cpu_rd(4'd0);
    // R11: master clear, then temporary reads zero and channel regs survive
    cpu_wr(4'd13, 8'h00);
    cpu_rd(4'd15);
    cpu_rd(4'd13);
    cpu_rd(4'd4);
    cpu_rd(4'd10);
    cpu_rd(4'd12);
    cpu_rd(4'd14);
    // random traffic against the model
    void'($urandom(32'h5EED_0A17));
    for (int n = 0; n < 500; n++) begin
      logic [3:0] ra;
      logic [7:0] rd_d;
      int sel;
      ra = 4'($urandom_range(0, 15));
      rd_d = 8'($urandom);
      sel = $urandom_range(0, 9);
      if (sel < 4) cpu_wr(ra, rd_d);
      else if (sel < 9) cpu_rd(ra);
      else ghost(ra, rd_d, rd_d[0]);
    end
    // R1: reset in the middle of traffic
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_c[i] = '0; m_mode[i] = '0; end
    model_ctrl_clear();
    cpu_rd(4'd15);
    cpu_rd(4'd11);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule